// File: doc/BRIEF.md
# Self-Routing Banyan Packet Network

This block switches up to N packets at once from N inlets to N outlets through log2 N columns of 2x2 switching elements. Each inlet presents a valid flag, a destination tag of log2 N bits and a payload word. No central controller takes part. In front of every column, a perfect shuffle rotates the line index left by one bit. Each element then looks only at the tag bit that belongs to its column, so a packet reaches the outlet named by its tag whatever inlet it entered on.

The network has no buffers. When two packets inside one element ask for the same output, the packet on the upper input goes through. The other packet is discarded and the conflict flag for that column is raised. The network can be combinational, or it can register every column so that a new set of packets enters each cycle.

Top module: `banyan_net`

## Requirements
- R1: With PIPELINED=1, a set of packets presented in one cycle appears at the outlets exactly log2 N clock cycles later. Sets presented in consecutive cycles stay separate, and an inlet with valid low produces no valid outlet.
- R2: A packet that meets no conflict leaves on the outlet whose index equals its tag (bit 0 of out_valid_o is outlet 0), whatever its inlet.
- R3: A set of packets whose paths share no element output, such as the identity mapping or any cyclic shift of destinations, is delivered complete with no conflict flag.
- R4: When both inputs of an element request the same output, the packet on the upper input (the even line after the shuffle) is delivered and the other packet is dropped.
- R5: conflict_o bit s, where bit 0 is the column nearest the inlets, is set when any element in column s drops a packet. With PIPELINED=1 it is set in the same cycle that column's result is registered.
- R6: An inlet with valid low takes no part in routing. Its tag cannot cause a conflict and cannot block another packet.
- R7: While rst_ni is low, out_valid_o and conflict_o are all zero.
- R8: Column s (counting from 0 at the inlets) uses tag bit log2 N - 1 - s, so the most significant bit is used first. Bit value 0 selects the element's upper output and bit value 1 selects its lower output.
- R9: A delivered packet's payload word leaves the network unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_PORTS | Per-inlet packet present |
| in_tag_i | input | N_PORTS x log2 N_PORTS | Per-inlet destination outlet index |
| in_data_i | input | N_PORTS x DATA_W | Per-inlet payload |
| out_valid_o | output | N_PORTS | Per-outlet packet present |
| out_data_o | output | N_PORTS x DATA_W | Per-outlet payload |
| conflict_o | output | log2 N_PORTS | Per-column packet-drop flag |

## Verification
Several properties are checked every cycle on the registered columns. A column with its conflict flag low passes on as many packets as entered it, and a column with the flag high passes on fewer. A column with no packets in produces none out. Every packet at the final column sits on the lane its tag names. The bench alone can show the rest, because only the scenarios reveal it: which packet wins a contended output, the exact latency, whether payloads are intact, that an idle inlet is ignored, and that the flag lands on the right column. These are covered by exhaustive single-packet routes, directed collisions and random sets, all compared against a reference model of the requirements.

// File: rtl/banyan_pkg.sv
package banyan_pkg;
  // perfect shuffle: one-bit left rotation of a line index
  function automatic int unsigned shuffle_pos(int unsigned idx, int unsigned bits);
    int unsigned mask;
    mask = (32'd1 << bits) - 1;
    return ((idx << 1) | (idx >> (bits - 1))) & mask;
  endfunction
endpackage

// File: rtl/banyan_se.sv
module banyan_se #(
  parameter int unsigned TAG_W   = 3,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SEL_BIT = 2
) (
  input  logic              up_v_i,
  input  logic [TAG_W-1:0]  up_tag_i,
  input  logic [DATA_W-1:0] up_data_i,
  input  logic              lo_v_i,
  input  logic [TAG_W-1:0]  lo_tag_i,
  input  logic [DATA_W-1:0] lo_data_i,
  output logic              o0_v_o,
  output logic [TAG_W-1:0]  o0_tag_o,
  output logic [DATA_W-1:0] o0_data_o,
  output logic              o1_v_o,
  output logic [TAG_W-1:0]  o1_tag_o,
  output logic [DATA_W-1:0] o1_data_o,
  output logic              conflict_o
);
  logic up_dir, lo_dir;

  assign up_dir     = up_tag_i[SEL_BIT];
  assign lo_dir     = lo_tag_i[SEL_BIT];
  assign conflict_o = up_v_i && lo_v_i && (up_dir == lo_dir);

  always_comb begin
    o0_v_o = 1'b0; o0_tag_o = up_tag_i; o0_data_o = up_data_i;
    o1_v_o = 1'b0; o1_tag_o = up_tag_i; o1_data_o = up_data_i;
    if (lo_v_i && !lo_dir) begin o0_v_o = 1'b1; o0_tag_o = lo_tag_i; o0_data_o = lo_data_i; end
    if (lo_v_i &&  lo_dir) begin o1_v_o = 1'b1; o1_tag_o = lo_tag_i; o1_data_o = lo_data_i; end
    // upper input assigned last: it wins a shared output
    if (up_v_i && !up_dir) begin o0_v_o = 1'b1; o0_tag_o = up_tag_i; o0_data_o = up_data_i; end
    if (up_v_i &&  up_dir) begin o1_v_o = 1'b1; o1_tag_o = up_tag_i; o1_data_o = up_data_i; end
  end
endmodule

// File: rtl/banyan_stage.sv
module banyan_stage import banyan_pkg::*; #(
  parameter int unsigned N_PORTS   = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned STAGE_IDX = 0,
  parameter bit          PIPELINED = 1'b1,
  localparam int unsigned LOG_N    = $clog2(N_PORTS),
  localparam int unsigned TAG_W    = LOG_N
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_PORTS-1:0]             v_i,
  input  logic [N_PORTS-1:0][TAG_W-1:0]  tag_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] data_i,
  output logic [N_PORTS-1:0]             v_o,
  output logic [N_PORTS-1:0][TAG_W-1:0]  tag_o,
  output logic [N_PORTS-1:0][DATA_W-1:0] data_o,
  output logic                           conflict_o
);
  localparam int unsigned N_SE    = N_PORTS / 2;
  localparam int unsigned SEL_BIT = TAG_W - 1 - STAGE_IDX;

  logic [N_PORTS-1:0]             sh_v, se_v;
  logic [N_PORTS-1:0][TAG_W-1:0]  sh_tag, se_tag;
  logic [N_PORTS-1:0][DATA_W-1:0] sh_data, se_data;
  logic [N_SE-1:0]                se_cf;
  logic                           cf_any;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_shuffle
    localparam int unsigned DST = shuffle_pos(i, LOG_N);
    assign sh_v[DST]    = v_i[i];
    assign sh_tag[DST]  = tag_i[i];
    assign sh_data[DST] = data_i[i];
  end

  for (genvar k = 0; k < N_SE; k++) begin : g_se
    banyan_se #(.TAG_W(TAG_W), .DATA_W(DATA_W), .SEL_BIT(SEL_BIT)) u_se (
      .up_v_i    (sh_v[2*k]),      .up_tag_i (sh_tag[2*k]),    .up_data_i(sh_data[2*k]),
      .lo_v_i    (sh_v[2*k+1]),    .lo_tag_i (sh_tag[2*k+1]),  .lo_data_i(sh_data[2*k+1]),
      .o0_v_o    (se_v[2*k]),      .o0_tag_o (se_tag[2*k]),    .o0_data_o(se_data[2*k]),
      .o1_v_o    (se_v[2*k+1]),    .o1_tag_o (se_tag[2*k+1]),  .o1_data_o(se_data[2*k+1]),
      .conflict_o(se_cf[k])
    );
  end

  assign cf_any = |se_cf;

  if (PIPELINED) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_o        <= '0;
        tag_o      <= '0;
        data_o     <= '0;
        conflict_o <= 1'b0;
      end else begin
        v_o        <= se_v;
        tag_o      <= se_tag;
        data_o     <= se_data;
        conflict_o <= cf_any;
      end
    end
  end else begin : g_comb
    assign v_o        = se_v;
    assign tag_o      = se_tag;
    assign data_o     = se_data;
    assign conflict_o = cf_any;
  end
endmodule

// File: rtl/banyan_net.sv
module banyan_net #(
  parameter int unsigned N_PORTS   = 8,
  parameter int unsigned DATA_W    = 16,
  parameter bit          PIPELINED = 1'b1,
  localparam int unsigned STAGES   = $clog2(N_PORTS),
  localparam int unsigned TAG_W    = STAGES
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_PORTS-1:0]             in_valid_i,
  input  logic [N_PORTS-1:0][TAG_W-1:0]  in_tag_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] in_data_i,
  output logic [N_PORTS-1:0]             out_valid_o,
  output logic [N_PORTS-1:0][DATA_W-1:0] out_data_o,
  output logic [STAGES-1:0]              conflict_o
);
  logic [STAGES:0][N_PORTS-1:0]             v_s;
  logic [STAGES:0][N_PORTS-1:0][TAG_W-1:0]  t_s;
  logic [STAGES:0][N_PORTS-1:0][DATA_W-1:0] d_s;

  assign v_s[0] = in_valid_i;
  assign t_s[0] = in_tag_i;
  assign d_s[0] = in_data_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_col
    banyan_stage #(
      .N_PORTS(N_PORTS), .DATA_W(DATA_W), .STAGE_IDX(s), .PIPELINED(PIPELINED)
    ) u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .v_i       (v_s[s]),
      .tag_i     (t_s[s]),
      .data_i    (d_s[s]),
      .v_o       (v_s[s+1]),
      .tag_o     (t_s[s+1]),
      .data_o    (d_s[s+1]),
      .conflict_o(conflict_o[s])
    );
  end

  assign out_valid_o = v_s[STAGES];
  assign out_data_o  = d_s[STAGES];
endmodule

// File: rtl/banyan_net_chk.sv
module banyan_net_chk #(
  parameter int unsigned N_PORTS   = 8,
  parameter bit          PIPELINED = 1'b1,
  localparam int unsigned STAGES   = $clog2(N_PORTS),
  localparam int unsigned TAG_W    = STAGES
) (
  input logic                                 clk_i,
  input logic                                 rst_ni,
  input logic [STAGES:0][N_PORTS-1:0]         v_s,
  input logic [STAGES:0][N_PORTS-1:0][TAG_W-1:0] t_s,
  input logic [STAGES-1:0]                    conflict_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  for (genvar i = 0; i < N_PORTS; i++) begin : g_lane
    // R2
    lane_tag_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_s[STAGES][i] |-> t_s[STAGES][i] == TAG_W'(i));
  end

  if (PIPELINED) begin : g_pipe
    for (genvar s = 0; s < STAGES; s++) begin : g_col
      // R5
      no_drop_without_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed && !conflict_o[s] |->
          $countones(v_s[s+1]) == $countones($past(v_s[s])));
      // R4
      flag_means_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed && conflict_o[s] |->
          $countones(v_s[s+1]) < $countones($past(v_s[s])));
      // R1
      idle_stays_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed && ($past(v_s[s]) == '0) |-> (v_s[s+1] == '0 && !conflict_o[s]));
    end
  end
endmodule

bind banyan_net banyan_net_chk #(.N_PORTS(N_PORTS), .PIPELINED(PIPELINED)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .v_s       (v_s),
  .t_s       (t_s),
  .conflict_o(conflict_o)
);

// File: tb/banyan_net_bench.sv
`timescale 1ns/1ps
module banyan_net_bench;
  localparam int unsigned N  = 8;
  localparam int unsigned DW = 16;
  localparam int unsigned ST = $clog2(N);
  localparam int unsigned TW = ST;
  localparam int unsigned NW = 48;

  typedef logic [N-1:0][TW-1:0] tag_vec_t;
  typedef logic [N-1:0][DW-1:0] dat_vec_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  in_v;
  tag_vec_t      in_t;
  dat_vec_t      in_d;
  logic [N-1:0]  out_valid_o;
  dat_vec_t      out_data_o;
  logic [ST-1:0] conflict_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  banyan_net #(.N_PORTS(N), .DATA_W(DW), .PIPELINED(1'b1)) u_banyan_net (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_v), .in_tag_i(in_t), .in_data_i(in_d),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .conflict_o(conflict_o)
  );

  // reference model built from R2, R4, R5, R6, R8
  task automatic model(input logic [N-1:0] v, input tag_vec_t t, input dat_vec_t d,
                       output logic [N-1:0] ov, output dat_vec_t od, output logic [ST-1:0] cf);
    logic [N-1:0] cv, sv;
    tag_vec_t ct, stg;
    dat_vec_t cd, sd;
    cv = v; ct = t; cd = d; cf = '0;
    for (int s = 0; s < ST; s++) begin
      sv = '0; stg = '0; sd = '0;
      for (int i = 0; i < N; i++) begin
        int p;
        p = ((i << 1) | (i >> (ST - 1))) % N;
        sv[p] = cv[i]; stg[p] = ct[i]; sd[p] = cd[i];
      end
      cv = '0;
      for (int k = 0; k < N/2; k++) begin
        logic bu, bl;
        bu = stg[2*k][TW-1-s];
        bl = stg[2*k+1][TW-1-s];
        if (sv[2*k]) begin
          cv[2*k+bu] = 1'b1; ct[2*k+bu] = stg[2*k]; cd[2*k+bu] = sd[2*k];
        end
        if (sv[2*k+1]) begin
          if (sv[2*k] && bu == bl) cf[s] = 1'b1;
          else begin cv[2*k+bl] = 1'b1; ct[2*k+bl] = stg[2*k+1]; cd[2*k+bl] = sd[2*k+1]; end
        end
      end
    end
    ov = cv; od = cd;
  endtask

  task automatic compare(input string req, input logic [N-1:0] ev, input dat_vec_t ed,
                         input bit chk_cf, input logic [ST-1:0] ecf, input logic [ST-1:0] acf);
    bit bad;
    checks++;
    if (out_valid_o !== ev) begin
      errors++;
      $display("FAIL %s valid act=%b exp=%b", req, out_valid_o, ev);
    end
    bad = 1'b0;
    for (int i = 0; i < N; i++) if (ev[i] && out_data_o[i] !== ed[i]) bad = 1'b1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s data act=%h exp=%h", req, out_data_o, ed);
    end
    if (chk_cf) begin
      checks++;
      if (acf !== ecf) begin
        errors++;
        $display("FAIL %s conflict act=%b exp=%b", req, acf, ecf);
      end
    end
  endtask

  // one set of packets, then idle until it drains
  task automatic seq_wave(input string req, input logic [N-1:0] v, input tag_vec_t t,
                          input dat_vec_t d, input bit force_cf, input logic [ST-1:0] fcf);
    logic [N-1:0] ev;
    dat_vec_t ed;
    logic [ST-1:0] ecf, acf;
    model(v, t, d, ev, ed, ecf);
    if (force_cf) ecf = fcf;
    @(negedge clk);
    in_v = v; in_t = t; in_d = d;
    acf = '0;
    for (int c = 1; c <= ST; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c == 1) in_v = '0;
      acf |= conflict_o;
    end
    compare(req, ev, ed, 1'b1, ecf, acf);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    tag_vec_t t;
    dat_vec_t d;
    logic [N-1:0] q_v[NW];
    dat_vec_t q_d[NW];
    logic [ST-1:0] dummy;
    void'($urandom(32'd7351));

    // R7: reset holds outputs low even with traffic present
    in_v = '1;
    for (int i = 0; i < N; i++) begin in_t[i] = TW'(i); in_d[i] = DW'(i); end
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid_o !== '0 || conflict_o !== '0) begin
      errors++;
      $display("FAIL R7 reset act=%b/%b exp=0/0", out_valid_o, conflict_o);
    end
    in_v = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R8 R9: every inlet to every outlet, alone
    for (int i = 0; i < N; i++)
      for (int tg = 0; tg < N; tg++) begin
        v = '0; v[i] = 1'b1; t = '0; t[i] = TW'(tg); d = '0; d[i] = DW'($urandom);
        seq_wave("R2_R8 single route", v, t, d, 1'b1, '0);
        checks++;
        if (out_valid_o !== (N'(1) << tg)) begin
          errors++;
          $display("FAIL R2 outlet act=%b exp=%b", out_valid_o, N'(1) << tg);
        end
      end

    // R3: identity and cyclic shifts are conflict-free
    for (int k = 0; k < N; k++) begin
      v = '1;
      for (int i = 0; i < N; i++) begin t[i] = TW'((i + k) % N); d[i] = DW'($urandom); end
      seq_wave("R3 shift", v, t, d, 1'b1, '0);
    end

    // R4 R5: inlets 0 and 4 meet in column 0 element 0, both want upper
    v = '0; v[0] = 1'b1; v[4] = 1'b1;
    t = '0; t[0] = 3'd0; t[4] = 3'd1;
    d = '0; d[0] = 16'hA0A0; d[4] = 16'hB4B4;
    seq_wave("R4_R5 column0 clash", v, t, d, 1'b1, 3'b001);
    checks++;
    if (out_valid_o !== 8'b0000_0001 || out_data_o[0] !== 16'hA0A0) begin
      errors++;
      $display("FAIL R4 winner act=%b/%h exp=00000001/a0a0", out_valid_o, out_data_o[0]);
    end

    // R5: same tag from two inlets collides at a later column
    v = '0; v[0] = 1'b1; v[1] = 1'b1;
    t = '0; t[0] = 3'd5; t[1] = 3'd5;
    d = '0; d[0] = 16'h1111; d[1] = 16'h2222;
    seq_wave("R5 same tag", v, t, d, 1'b0, '0);

    // R6: idle inlet with a clashing tag is ignored
    v = '0; v[4] = 1'b1;
    t = '0; t[0] = 3'd0; t[4] = 3'd1;
    d = '0; d[0] = 16'hDEAD; d[4] = 16'h4444;
    seq_wave("R6 idle inlet", v, t, d, 1'b1, '0);

    // R4 R5 R9: random sets
    for (int w = 0; w < 150; w++) begin
      v = N'($urandom);
      for (int i = 0; i < N; i++) begin t[i] = TW'($urandom); d[i] = DW'($urandom); end
      seq_wave("R4_R5 random", v, t, d, 1'b0, '0);
    end

    // R1: back-to-back sets, latency ST cycles
    for (int c = 0; c < NW + ST; c++) begin
      @(negedge clk);
      if (c >= ST) compare("R1 stream", q_v[c-ST], q_d[c-ST], 1'b0, '0, '0);
      if (c < NW) begin
        v = N'($urandom);
        for (int i = 0; i < N; i++) begin t[i] = TW'($urandom); d[i] = DW'($urandom); end
        model(v, t, d, q_v[c], q_d[c], dummy);
        in_v = v; in_t = t; in_d = d;
      end else begin
        in_v = '0;
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule